// File: doc/BRIEF.md
# Aligned PWM Channel Generator

This block produces one pulse-width-modulated waveform. A prescaler turns the peripheral clock, or one of two external clock enables, into count ticks. A period counter steps on those ticks. In edge-aligned mode the counter only counts up and wraps. In center-aligned mode it counts up to the period value and then back down. A comparator turns the counter value and the duty value into the compare waveform. A polarity bit fixes the level at which each period starts. A separate invert bit sets the level that is held while the channel is off.

Period and duty values are written into a shadow stage. They move into the active stage only at a counter boundary, and which boundary depends on the alignment mode and an update-select bit. The block also emits a one-cycle counter-event strobe at period boundaries, and optionally at the half-period point in center mode. A trigger output forwards either the compare waveform or the strobe.

Configuration sits in a mode register. A write is dropped while either write-protect flag is high.

The counter controller is a three-state machine:
- `ST_OFF` is the channel-disabled state. It holds the counter at 0 and lets pending shadow values load.
- `ST_UP` counts up.
- `ST_DOWN` counts down, in center mode only.

Its transitions are:
- enable (`ST_OFF`→`ST_UP`)
- wrap (`ST_UP`→`ST_UP` at the period end in edge mode)
- turn (`ST_UP`→`ST_DOWN` at the top in center mode, which is the half-period point)
- bottom (`ST_DOWN`→`ST_UP` at the period end in center mode)
- disable (any state→`ST_OFF` when the enable input drops)

Top module: `pwm_chan`

## Requirements
- R1: After reset every mode field is 0. The channel is off, so `wave_o`, `cevt_o` and `trig_o` are all low.
- R2: While the channel is disabled, `wave_o` equals the start-level bit (`mode_wdata[5]`) XOR the off-invert bit (`mode_wdata[8]`).
- R3: A mode write (`mode_wr`) is dropped while `wp_a` or `wp_b` is high. The register keeps its previous value.
- R4: Edge-aligned mode (`mode_wdata[4]`=0): the counter steps 0..P-1, so one period lasts P ticks. `wave_o` starts each period at the start level and takes the opposite level for the last D ticks. The counter event fires once per period, on its final tick.
- R5: Center-aligned mode (`mode_wdata[4]`=1): the counter steps 0..P and back to 1, so one period lasts 2P ticks. `wave_o` takes the opposite level while the counter is at or above P-D.
- R6: A duty of 0 holds the start level for the whole period. A duty at or above P holds the opposite level for the whole period.
- R7: In center mode the counter event fires at the period end. With `mode_wdata[6]`=1 it also fires at the top. In edge mode that bit has no effect.
- R8: Buffered period and duty values load at the period end. In center mode with `mode_wdata[7]`=1 they also load at the top. In edge mode `mode_wdata[7]` is ignored.
- R9: An update written while an earlier one is still pending replaces it.
- R10: Prescaler codes 0..10 (`mode_wdata[3:0]`) give one tick every 2^code peripheral clocks.
- R11: Code 11 ticks on `ext_a`, code 12 ticks on `ext_b`, and codes 13..15 stop the counter.
- R12: With `mode_wdata[9]`=0, `trig_o` follows `wave_o`. With `mode_wdata[9]`=1, `trig_o` follows `cevt_o`.
- R13: Each counter event is one peripheral-clock cycle wide. It is high only in the cycle of the tick that reaches the boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_a | input | 1 | External clock enable A |
| ext_b | input | 1 | External clock enable B |
| chan_en | input | 1 | Channel enable |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | 10 | Mode word: [9] trigger select, [8] off invert, [7] update select, [6] event select, [5] start level, [4] center align, [3:0] prescale code |
| wp_a | input | 1 | Write-protect flag one |
| wp_b | input | 1 | Write-protect flag two |
| upd_wr | input | 1 | Shadow update strobe |
| upd_per | input | CW | New period value |
| upd_dty | input | CW | New duty value |
| wave_o | output | 1 | Compare waveform |
| cevt_o | output | 1 | Counter-event strobe |
| trig_o | output | 1 | Trigger output |

## Verification
The following are checked by assertions on every cycle:
- a protected write leaves the mode register untouched;
- a disabled channel shows the off level;
- the stop codes never produce an event;
- events occur only on ticks;
- half-period events occur only in center mode;
- the active stage changes only on a load strobe.

Waveform shapes, duty extremes, tick spacing per prescale code and the trigger choice can only be shown by the directed scenarios, which count high cycles and events over full periods. The same holds for the different load points of the update-select bit and the replacement of a pending update.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int PRESC_W    = 4;
    localparam int PKG_MAXEXP = 10;
    localparam logic [PRESC_W-1:0] CODE_EXT_A = 4'd11;
    localparam logic [PRESC_W-1:0] CODE_EXT_B = 4'd12;

    typedef struct packed {
        logic               trig_sel;
        logic               dis_inv;
        logic               upd_sel;
        logic               cevt_sel;
        logic               pol;
        logic               align;
        logic [PRESC_W-1:0] presc;
    } mode_t;

    localparam int MODE_W = $bits(mode_t);

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_UP   = 2'd1,
        ST_DOWN = 2'd2
    } state_t;

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
    import pwm_pkg::*;
#(
    parameter int MAXEXP = PKG_MAXEXP
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [PRESC_W-1:0] code,
    input  logic               ext_a,
    input  logic               ext_b,
    output logic               tick
);

    localparam int DW = MAXEXP;
    localparam logic [PRESC_W-1:0] CODE_MAX = PRESC_W'(MAXEXP);

    logic [DW-1:0] div_q;
    logic [DW-1:0] mask;

    // Low-order bits that must all be set for a divided tick.
    generate
        for (genvar i = 0; i < DW; i++) begin : g_mask
            assign mask[i] = (code > PRESC_W'(i));
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (!run) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + DW'(1);
        end
    end

    always_comb begin
        if (code <= CODE_MAX) begin
            tick = run && ((div_q & mask) == mask);
        end else if (code == CODE_EXT_A) begin
            tick = run && ext_a;
        end else if (code == CODE_EXT_B) begin
            tick = run && ext_b;
        end else begin
            tick = 1'b0;
        end
    end

endmodule

// File: rtl/pwm_shadow.sv
module pwm_shadow #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd_wr,
    input  logic [CW-1:0] upd_per,
    input  logic [CW-1:0] upd_dty,
    input  logic          load,
    output logic [CW-1:0] act_per,
    output logic [CW-1:0] act_dty,
    output logic [CW-1:0] nxt_per
);

    logic [CW-1:0] sh_per_q, sh_dty_q;
    logic          pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_per_q <= '0;
            sh_dty_q <= '0;
            pend_q   <= 1'b0;
            act_per  <= '0;
            act_dty  <= '0;
        end else begin
            if (upd_wr) begin
                sh_per_q <= upd_per;
                sh_dty_q <= upd_dty;
                pend_q   <= 1'b1;
            end else if (load) begin
                pend_q   <= 1'b0;
            end
            if (load && pend_q) begin
                act_per <= sh_per_q;
                act_dty <= sh_dty_q;
            end
        end
    end

    assign nxt_per = pend_q ? sh_per_q : act_per;

    // R8: the active stage only moves on a load strobe
    p_load_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(act_per) && $stable(act_dty)));

endmodule

// File: rtl/pwm_period_fsm.sv
module pwm_period_fsm
    import pwm_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chan_en,
    input  logic          tick,
    input  logic          align,
    input  logic          upd_sel,
    input  logic [CW-1:0] act_per,
    input  logic [CW-1:0] nxt_per,
    output logic [CW-1:0] cnt,
    output logic          running,
    output logic          end_evt,
    output logic          half_evt,
    output logic          load
);

    state_t        st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          at_top, at_bot;

    assign at_top = (({1'b0, cnt_q} + (CW+1)'(1)) >= {1'b0, act_per});
    assign at_bot = (cnt_q <= CW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_OFF;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Next state and counter value.
    always_comb begin
        st_d     = st_q;
        cnt_d    = cnt_q;
        end_evt  = 1'b0;
        half_evt = 1'b0;
        unique case (st_q)
            ST_OFF: begin
                cnt_d = '0;
                if (chan_en) st_d = ST_UP;
            end
            ST_UP: begin
                if (!chan_en) begin
                    st_d  = ST_OFF;
                    cnt_d = '0;
                end else if (tick) begin
                    if (at_top) begin
                        if (align) begin
                            half_evt = 1'b1;
                            st_d     = ST_DOWN;
                            cnt_d    = upd_sel ? nxt_per : act_per;
                        end else begin
                            end_evt  = 1'b1;
                            cnt_d    = '0;
                        end
                    end else begin
                        cnt_d = cnt_q + CW'(1);
                    end
                end
            end
            ST_DOWN: begin
                if (!chan_en) begin
                    st_d  = ST_OFF;
                    cnt_d = '0;
                end else if (tick) begin
                    if (at_bot) begin
                        end_evt = 1'b1;
                        st_d    = ST_UP;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q - CW'(1);
                    end
                end
            end
            default: begin
                st_d  = ST_OFF;
                cnt_d = '0;
            end
        endcase
    end

    // Outputs of the state machine.
    always_comb begin
        running = (st_q != ST_OFF);
        load    = (st_q == ST_OFF) || end_evt || (half_evt && upd_sel);
        cnt     = cnt_q;
    end

    // R7: a half-period event only exists in center mode
    p_half_center_r7: assert property (@(posedge clk) disable iff (!rst_n)
        half_evt |-> align);

    // R13: boundary events coincide with a count tick
    p_evt_on_tick_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (end_evt || half_evt) |-> tick);

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
    import pwm_pkg::*;
#(
    parameter int CW     = 16,
    parameter int MAXEXP = PKG_MAXEXP
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_a,
    input  logic              ext_b,
    input  logic              chan_en,
    input  logic              mode_wr,
    input  logic [MODE_W-1:0] mode_wdata,
    input  logic              wp_a,
    input  logic              wp_b,
    input  logic              upd_wr,
    input  logic [CW-1:0]     upd_per,
    input  logic [CW-1:0]     upd_dty,
    output logic              wave_o,
    output logic              cevt_o,
    output logic              trig_o
);

    mode_t         mode_q;
    logic          tick, running, end_evt, half_evt, load;
    logic [CW-1:0] cnt, act_per, act_dty, nxt_per, th;
    logic          flip;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (mode_wr && !wp_a && !wp_b) begin
            mode_q <= mode_t'(mode_wdata);
        end
    end

    pwm_prescaler #(.MAXEXP(MAXEXP)) presc_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (chan_en),
        .code  (mode_q.presc),
        .ext_a (ext_a),
        .ext_b (ext_b),
        .tick  (tick)
    );

    pwm_period_fsm #(.CW(CW)) fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .chan_en  (chan_en),
        .tick     (tick),
        .align    (mode_q.align),
        .upd_sel  (mode_q.upd_sel),
        .act_per  (act_per),
        .nxt_per  (nxt_per),
        .cnt      (cnt),
        .running  (running),
        .end_evt  (end_evt),
        .half_evt (half_evt),
        .load     (load)
    );

    pwm_shadow #(.CW(CW)) shadow_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd_wr  (upd_wr),
        .upd_per (upd_per),
        .upd_dty (upd_dty),
        .load    (load),
        .act_per (act_per),
        .act_dty (act_dty),
        .nxt_per (nxt_per)
    );

    // Opposite level from threshold P-D upward; duty 0 never flips.
    always_comb begin
        th     = (act_dty >= act_per) ? '0 : (act_per - act_dty);
        flip   = (act_dty != '0) && (cnt >= th);
        wave_o = running ? (mode_q.pol ^ flip) : (mode_q.pol ^ mode_q.dis_inv);
        cevt_o = end_evt || (half_evt && mode_q.cevt_sel);
        trig_o = mode_q.trig_sel ? cevt_o : wave_o;
    end

    // R3: a protected write leaves the mode register untouched
    p_wp_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && (wp_a || wp_b)) |=> $stable(mode_q));

    // R2: after a full cycle disabled, the off level is shown
    p_dis_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!chan_en && $past(!chan_en)) |-> (wave_o == (mode_q.pol ^ mode_q.dis_inv)));

    // R11: stop codes never produce a counter event
    p_stop_codes_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q.presc > CODE_EXT_B) |-> !cevt_o);

endmodule

// File: tb/pwm_chan_tb.sv
module pwm_chan_tb_top;

    localparam int CLK_P = 10;
    localparam int CW    = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ext_a = 1'b0, ext_b = 1'b0, chan_en = 1'b0;
    logic          mode_wr = 1'b0, wp_a = 1'b0, wp_b = 1'b0, upd_wr = 1'b0;
    logic [9:0]    mode_wdata = '0;
    logic [CW-1:0] upd_per = '0, upd_dty = '0;
    logic          wave_o, cevt_o, trig_o;

    int checks = 0;
    int errors = 0;
    int cur_per = 0;
    bit ext_a_gen = 1'b0;

    pwm_chan #(.CW(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .ext_a(ext_a), .ext_b(ext_b),
        .chan_en(chan_en), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .wp_a(wp_a), .wp_b(wp_b), .upd_wr(upd_wr), .upd_per(upd_per),
        .upd_dty(upd_dty), .wave_o(wave_o), .cevt_o(cevt_o), .trig_o(trig_o)
    );

    always #(CLK_P/2) clk = ~clk;

    // External enable A: one pulse every third clock when active.
    initial begin
        int k = 0;
        forever begin
            @(negedge clk);
            if (ext_a_gen) begin
                ext_a = (k % 3 == 0);
                k++;
            end else begin
                ext_a = 1'b0;
                k = 0;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [9:0] mw(input bit trg, input bit inv, input bit ups,
                                      input bit ces, input bit pol, input bit ctr,
                                      input int code);
        return {trg, inv, ups, ces, pol, ctr, 4'(code)};
    endfunction

    task automatic write_mode(input logic [9:0] w);
        @(negedge clk);
        mode_wr = 1'b1; mode_wdata = w;
        @(negedge clk);
        mode_wr = 1'b0;
    endtask

    task automatic setup(input logic [9:0] w, input int per, input int dty);
        chan_en = 1'b0;
        repeat (2) @(negedge clk);
        write_mode(w);
        cur_per = per;
        upd_wr = 1'b1; upd_per = CW'(per); upd_dty = CW'(dty);
        @(negedge clk);
        upd_wr = 1'b0;
        @(negedge clk);
        chan_en = 1'b1;
    endtask

    task automatic sync(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (cevt_o) begin ok = 1'b1; break; end
        end
    endtask

    // Counts high cycles and events over n cycles; optional updates at i=0 and i=1.
    task automatic measure(input int n, input int n_upd, input int d1, input int d2,
                           output int hi, output int ev);
        hi = 0; ev = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            hi += int'(wave_o);
            ev += int'(cevt_o);
            if (n_upd >= 1 && i == 0) begin
                upd_wr = 1'b1; upd_per = CW'(cur_per); upd_dty = CW'(d1);
            end else if (n_upd >= 2 && i == 1) begin
                upd_wr = 1'b1; upd_per = CW'(cur_per); upd_dty = CW'(d2);
            end else begin
                upd_wr = 1'b0;
            end
        end
        upd_wr = 1'b0;
    endtask

    task automatic spacing(output int sp);
        bit ok;
        sp = -1;
        sync(ok);
        if (ok) begin
            for (int i = 1; i <= 3000; i++) begin
                @(negedge clk);
                if (cevt_o) begin sp = i; break; end
            end
        end
    endtask

    task automatic t_reset();
        chk("R1 wave at reset", int'(wave_o), 0);
        chk("R1 cevt at reset", int'(cevt_o), 0);
        chk("R1 trig at reset", int'(trig_o), 0);
    endtask

    task automatic t_disabled();
        int hi, ev;
        write_mode(mw(0,0,0,0,1,0,0));
        @(negedge clk);
        chk("R2 off level pol=1", int'(wave_o), 1);
        write_mode(mw(0,1,0,0,1,0,0));
        @(negedge clk);
        chk("R2 off level pol=1 inv=1", int'(wave_o), 0);
        setup(mw(0,1,0,0,1,0,0), 8, 3);
        measure(10, 0, 0, 0, hi, ev);
        chan_en = 1'b0;
        repeat (2) @(negedge clk);
        chk("R2 off level after run", int'(wave_o), 0);
    endtask

    task automatic t_wprot();
        chan_en = 1'b0;
        write_mode(mw(0,0,0,0,1,0,0));
        wp_a = 1'b1;
        write_mode(mw(0,0,0,0,0,0,0));
        @(negedge clk);
        chk("R3 write blocked by wp_a", int'(wave_o), 1);
        wp_a = 1'b0; wp_b = 1'b1;
        write_mode(mw(0,0,0,0,0,0,0));
        @(negedge clk);
        chk("R3 write blocked by wp_b", int'(wave_o), 1);
        wp_b = 1'b0;
        write_mode(mw(0,0,0,0,0,0,0));
        @(negedge clk);
        chk("R3 write accepted unprotected", int'(wave_o), 0);
    endtask

    task automatic t_left();
        int hi, ev;
        bit ok;
        setup(mw(0,0,0,0,0,0,0), 8, 3);
        sync(ok);
        @(negedge clk);
        chk("R4 start level at period start", int'(wave_o), 0);
        measure(8, 0, 0, 0, hi, ev);
        chk("R4 edge high cycles", hi, 3);
        chk("R4 edge events per period", ev, 1);
        setup(mw(0,0,0,1,0,0,0), 8, 3);
        sync(ok);
        measure(8, 0, 0, 0, hi, ev);
        chk("R7 edge ignores event select", ev, 1);
    endtask

    task automatic t_center();
        int hi, ev;
        bit ok;
        setup(mw(0,0,0,0,0,1,0), 4, 1);
        sync(ok);
        measure(8, 0, 0, 0, hi, ev);
        chk("R5 center high cycles", hi, 3);
        chk("R7 center end-only events", ev, 1);
        setup(mw(0,0,0,1,0,1,0), 4, 1);
        sync(ok);
        measure(8, 0, 0, 0, hi, ev);
        chk("R7 center end and half events", ev, 2);
    endtask

    task automatic t_duty_ext();
        int hi, ev;
        bit ok;
        setup(mw(0,0,0,0,0,0,0), 8, 0);
        sync(ok);
        measure(8, 0, 0, 0, hi, ev);
        chk("R6 edge duty 0", hi, 0);
        setup(mw(0,0,0,0,0,0,0), 8, 9);
        sync(ok);
        measure(8, 0, 0, 0, hi, ev);
        chk("R6 edge duty above period", hi, 8);
        setup(mw(0,0,0,0,0,1,0), 4, 0);
        sync(ok);
        measure(8, 0, 0, 0, hi, ev);
        chk("R6 center duty 0", hi, 0);
        setup(mw(0,0,0,0,0,1,0), 4, 4);
        sync(ok);
        measure(8, 0, 0, 0, hi, ev);
        chk("R6 center duty equal period", hi, 8);
    endtask

    task automatic t_update();
        int hi, ev;
        bit ok;
        setup(mw(0,0,0,0,0,1,0), 4, 1);
        sync(ok);
        measure(16, 1, 4, 0, hi, ev);
        chk("R8 center load at period end", hi, 11);
        setup(mw(0,0,1,0,0,1,0), 4, 1);
        sync(ok);
        measure(16, 1, 4, 0, hi, ev);
        chk("R8 center load at half period", hi, 13);
        setup(mw(0,0,1,0,0,0,0), 8, 3);
        sync(ok);
        measure(16, 1, 8, 0, hi, ev);
        chk("R8 edge ignores update select", hi, 11);
    endtask

    task automatic t_pending();
        int hi, ev;
        bit ok;
        setup(mw(0,0,0,0,0,1,0), 4, 1);
        sync(ok);
        measure(16, 2, 4, 0, hi, ev);
        chk("R9 pending update replaced", hi, 3);
    endtask

    task automatic t_presc();
        int sp, hi, ev;
        bit ok;
        setup(mw(0,0,0,0,0,0,0), 5, 2);
        spacing(sp);
        chk("R10 code 0 spacing", sp, 5);
        setup(mw(0,0,0,0,0,0,2), 2, 1);
        spacing(sp);
        chk("R10 code 2 spacing", sp, 8);
        sync(ok);
        measure(8, 0, 0, 0, hi, ev);
        chk("R10 code 2 high cycles", hi, 4);
        setup(mw(0,0,0,0,0,0,10), 1, 0);
        spacing(sp);
        chk("R10 code 10 spacing", sp, 1024);
        setup(mw(0,0,0,0,0,0,2), 1, 0);
        sync(ok);
        measure(8, 0, 0, 0, hi, ev);
        chk("R13 one-cycle events", ev, 2);
    endtask

    task automatic t_ext();
        int sp, hi, ev;
        ext_a_gen = 1'b1;
        ext_b = 1'b1;
        setup(mw(0,0,0,0,0,0,11), 2, 1);
        spacing(sp);
        chk("R11 code 11 follows ext_a", sp, 6);
        setup(mw(0,0,0,0,0,0,12), 2, 1);
        spacing(sp);
        chk("R11 code 12 follows ext_b", sp, 2);
        ext_b = 1'b0;
        setup(mw(0,0,0,0,0,0,12), 2, 1);
        measure(40, 0, 0, 0, hi, ev);
        chk("R11 code 12 ext_b idle", ev, 0);
        ext_b = 1'b1;
        setup(mw(0,0,0,0,0,0,14), 2, 1);
        measure(40, 0, 0, 0, hi, ev);
        chk("R11 stop code 14", ev, 0);
        ext_a_gen = 1'b0;
        ext_b = 1'b0;
    endtask

    task automatic t_trig();
        int bad;
        bit ok;
        setup(mw(0,0,0,0,0,0,0), 4, 1);
        sync(ok);
        bad = 0;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (trig_o !== wave_o) bad++;
        end
        chk("R12 trigger follows waveform", bad, 0);
        setup(mw(1,0,0,0,0,0,0), 4, 1);
        sync(ok);
        bad = 0;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (trig_o !== cevt_o) bad++;
        end
        chk("R12 trigger follows events", bad, 0);
    endtask

    initial begin
        #(CLK_P * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_wprot();
        t_left();
        t_center();
        t_duty_ext();
        t_update();
        t_pending();
        t_presc();
        t_ext();
        t_trig();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule